// File: doc/BRIEF.md
# Tree and Butterfly Route Stepper

This block holds the hop-by-hop routing decision for one packet crossing a binary tree or a binary butterfly network. A source and a destination leaf address are loaded together. The block then produces one output port decision for each accepted step request, until the packet reaches its destination. The relative route word is the XOR of the two addresses.

In tree mode, the packet first climbs toward the common ancestor. The number of levels climbed is one more than the position of the highest set bit of the route word. It then descends, and the child at each level is picked by the destination bits below that point, starting with the highest of them. In butterfly mode, every route crosses all stages in ascending order. At each stage, the matching bit of the route word chooses between the straight edge and the cross edge.

The topology is fixed at elaboration by the `MODE` parameter (0 = tree, 1 = butterfly). The address width `AW` is also a parameter (default 4: 16 leaves or 16 nodes). Loads and steps each use a valid/ready handshake. Every output is registered.

Top module: `route_stepper`

## Requirements
- R1: After reset, `ld_ready`=1, `stp_ready`=0, `done_o`=0, `hop_valid_o`=0, `level_o`=0 and `port_o`=0.
- R2: A load is taken when `ld_valid` and `ld_ready` are both 1. `ld_ready` is 1 when the block is idle or done, and 0 while a route is in progress. A load offered during a route is ignored. A taken load that does not deliver at once sets `level_o`=0 and `done_o`=0, and raises `stp_ready` in the next cycle.
- R3: In tree mode, a load whose route word is zero delivers at once. In the next cycle `done_o`=1, `hop_valid_o`=1, `level_o`=0 and `port_o`=3 (local).
- R4: In tree mode, with i the index of the highest set bit of the route word, the first i+1 steps each give `port_o`=2 (up) and raise `level_o` by one.
- R5: In tree mode, the following i+1 steps use destination bits i down to 0 in that order. The step for bit j gives `port_o`=0 (left child) when the bit is 0, or 1 (right child) when it is 1, and leaves `level_o`=j. `done_o` rises with the step for bit 0.
- R6: In butterfly mode, a route takes exactly AW steps, even when the route word is zero. Step k (counting from 0) gives `port_o`=0 (straight) when bit k of the route word is 0, or 1 (cross) when it is 1, and sets `level_o`=k+1. `done_o` rises with the last step.
- R7: A step is taken only when `stp_valid` and `stp_ready` are both 1. `stp_ready` is 1 only while a route is in progress. Each taken step, and each immediate local delivery, pulses `hop_valid_o` for exactly one cycle. While no step is taken, `level_o` stays unchanged.
- R8: Once `done_o` is 1, it stays 1 with `port_o` and `level_o` unchanged until the next load. Step requests in this state are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Offer of a new source/destination pair |
| ld_ready | output | 1 | Block can accept a load |
| ld_src | input | AW | Source leaf address |
| ld_dst | input | AW | Destination leaf address |
| stp_valid | input | 1 | Request for the next hop decision |
| stp_ready | output | 1 | Route in progress; a step can be taken |
| port_o | output | 2 | Last decision: 0 left/straight, 1 right/cross, 2 up, 3 local |
| level_o | output | $clog2(AW+1) | Tree level after the hop, or butterfly stages crossed |
| hop_valid_o | output | 1 | One-cycle pulse for each new decision |
| done_o | output | 1 | Packet has reached its destination |

## Verification
The assertions check several rules on every cycle:
- the two ready outputs never rise together;
- each hop pulse follows a taken step or a taken load;
- a stalled route holds its level;
- a finished route holds its decision;
- an up hop raises the level by one;
- a tree route ends at level zero, and a butterfly route ends after AW stages.

Only the bench's sweeps can show the exact port sequences. These are the climb length set by the highest route bit, the descent bits taken from the destination from high to low, and the straight or cross choice at each stage. The sweeps cover every source/destination pair in both modes. Directed cases cover a stalled step and a load offered during a route.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    PORT_LO    = 2'b00,
    PORT_HI    = 2'b01,
    PORT_UP    = 2'b10,
    PORT_LOCAL = 2'b11
  } port_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } st_e;

  localparam int MODE_TREE = 0;
  localparam int MODE_FLY  = 1;
endpackage

// File: rtl/rs_msb_find.sv
module rs_msb_find #(
  parameter int W  = 4,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int k = 0; k < W; k++) begin
      if (vec[k]) begin
        any = 1'b1;
        idx = IW'(k);
      end
    end
  end
endmodule

// File: rtl/rs_tree_next.sv
module rs_tree_next
  import rs_pkg::*;
#(
  parameter int AW = 4,
  parameter int LW = $clog2(AW + 1)
) (
  input  logic [AW-1:0] dst,
  input  logic [LW-1:0] up_left,
  input  logic [LW-1:0] down_left,
  input  logic [LW-1:0] level,
  output port_e         port,
  output logic [LW-1:0] nxt_up,
  output logic [LW-1:0] nxt_down,
  output logic [LW-1:0] nxt_level,
  output logic          last
);
  logic [LW-1:0] bit_idx;
  logic [AW-1:0] dst_sh;

  always_comb begin
    bit_idx = down_left - LW'(1);
    dst_sh  = dst >> bit_idx;
    if (up_left != '0) begin
      port      = PORT_UP;
      nxt_up    = up_left - LW'(1);
      nxt_down  = down_left;
      nxt_level = level + LW'(1);
      last      = 1'b0;
    end else begin
      port      = dst_sh[0] ? PORT_HI : PORT_LO;
      nxt_up    = '0;
      nxt_down  = down_left - LW'(1);
      nxt_level = level - LW'(1);
      last      = (down_left == LW'(1));
    end
  end
endmodule

// File: rtl/rs_fly_next.sv
module rs_fly_next
  import rs_pkg::*;
#(
  parameter int AW = 4,
  parameter int LW = $clog2(AW + 1)
) (
  input  logic [AW-1:0] rword,
  input  logic [LW-1:0] stage,
  output port_e         port,
  output logic [LW-1:0] nxt_stage,
  output logic          last
);
  logic [AW-1:0] r_sh;

  always_comb begin
    r_sh      = rword >> stage;
    port      = r_sh[0] ? PORT_HI : PORT_LO;
    nxt_stage = stage + LW'(1);
    last      = (stage == LW'(AW - 1));
  end
endmodule

// File: rtl/route_stepper.sv
module route_stepper
  import rs_pkg::*;
#(
  parameter int AW   = 4,
  parameter int MODE = 0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ld_valid,
  output logic                     ld_ready,
  input  logic [AW-1:0]            ld_src,
  input  logic [AW-1:0]            ld_dst,
  input  logic                     stp_valid,
  output logic                     stp_ready,
  output logic [1:0]               port_o,
  output logic [$clog2(AW+1)-1:0]  level_o,
  output logic                     hop_valid_o,
  output logic                     done_o
);
  localparam int LW = $clog2(AW + 1);
  localparam int IW = (AW > 1) ? $clog2(AW) : 1;

  st_e           state_q;
  logic [AW-1:0] route_q;
  logic [LW-1:0] up_q, down_q, level_q;
  port_e         port_q;
  logic          hop_q;

  logic [AW-1:0] rword;
  logic [AW-1:0] ld_route;
  logic [LW-1:0] ld_up;
  logic          ld_local;
  port_e         n_port;
  logic [LW-1:0] n_up, n_down, n_level;
  logic          n_last;
  logic          ld_fire, stp_fire;

  assign rword     = ld_src ^ ld_dst;
  assign ld_ready  = (state_q != ST_RUN);
  assign stp_ready = (state_q == ST_RUN);
  assign ld_fire   = ld_valid && ld_ready;
  assign stp_fire  = stp_valid && stp_ready;

  generate
    if (MODE == MODE_TREE) begin : g_tree
      logic          r_any;
      logic [IW-1:0] r_msb;

      rs_msb_find #(.W(AW), .IW(IW)) msb_i (
        .vec(rword),
        .any(r_any),
        .idx(r_msb)
      );

      assign ld_route = ld_dst;
      assign ld_local = !r_any;
      assign ld_up    = r_any ? (LW'(r_msb) + LW'(1)) : '0;

      rs_tree_next #(.AW(AW), .LW(LW)) next_i (
        .dst(route_q),
        .up_left(up_q),
        .down_left(down_q),
        .level(level_q),
        .port(n_port),
        .nxt_up(n_up),
        .nxt_down(n_down),
        .nxt_level(n_level),
        .last(n_last)
      );
    end else begin : g_fly
      assign ld_route = rword;
      assign ld_local = 1'b0;
      assign ld_up    = '0;
      assign n_up     = '0;
      assign n_down   = '0;

      rs_fly_next #(.AW(AW), .LW(LW)) next_i (
        .rword(route_q),
        .stage(level_q),
        .port(n_port),
        .nxt_stage(n_level),
        .last(n_last)
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      route_q <= '0;
      up_q    <= '0;
      down_q  <= '0;
      level_q <= '0;
      port_q  <= PORT_LO;
      hop_q   <= 1'b0;
    end else begin
      hop_q <= 1'b0;
      if (ld_fire) begin
        route_q <= ld_route;
        up_q    <= ld_up;
        down_q  <= ld_up;
        level_q <= '0;
        if (ld_local) begin
          state_q <= ST_DONE;
          port_q  <= PORT_LOCAL;
          hop_q   <= 1'b1;
        end else begin
          state_q <= ST_RUN;
          port_q  <= PORT_LO;
        end
      end else if (stp_fire) begin
        up_q    <= n_up;
        down_q  <= n_down;
        level_q <= n_level;
        port_q  <= n_port;
        hop_q   <= 1'b1;
        if (n_last) state_q <= ST_DONE;
      end
    end
  end

  assign port_o      = port_q;
  assign level_o     = level_q;
  assign hop_valid_o = hop_q;
  assign done_o      = (state_q == ST_DONE);
endmodule

// File: rtl/route_stepper_chk.sv
module route_stepper_chk #(
  parameter int AW   = 4,
  parameter int MODE = 0
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    ld_valid,
  input logic                    ld_ready,
  input logic                    stp_valid,
  input logic                    stp_ready,
  input logic [1:0]              port_o,
  input logic [$clog2(AW+1)-1:0] level_o,
  input logic                    hop_valid_o,
  input logic                    done_o
);
  localparam int LW = $clog2(AW + 1);

  p_ready_mutex_r2: assert property (@(posedge clk) disable iff (rst)
    !(ld_ready && stp_ready));

  p_hop_cause_r7: assert property (@(posedge clk) disable iff (rst)
    hop_valid_o |-> ($past(stp_valid && stp_ready) || $past(ld_valid && ld_ready)));

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (stp_ready && !stp_valid) |=> ($stable(level_o) && !hop_valid_o));

  p_done_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (done_o && !ld_valid) |=> (done_o && $stable(port_o) && $stable(level_o)));

  generate
    if (MODE == 0) begin : g_tree_chk
      p_climb_r4: assert property (@(posedge clk) disable iff (rst)
        (hop_valid_o && port_o == 2'b10) |-> (level_o == LW'($past(level_o) + LW'(1))));

      p_home_r5: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (level_o == '0));

      p_local_r3: assert property (@(posedge clk) disable iff (rst)
        (hop_valid_o && port_o == 2'b11) |-> (done_o && level_o == '0));
    end else begin : g_fly_chk
      p_depth_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (level_o == LW'(AW)));

      p_no_updown_r6: assert property (@(posedge clk) disable iff (rst)
        !port_o[1]);
    end
  endgenerate
endmodule

bind route_stepper route_stepper_chk #(.AW(AW), .MODE(MODE)) chk_i (
  .clk(clk),
  .rst(rst),
  .ld_valid(ld_valid),
  .ld_ready(ld_ready),
  .stp_valid(stp_valid),
  .stp_ready(stp_ready),
  .port_o(port_o),
  .level_o(level_o),
  .hop_valid_o(hop_valid_o),
  .done_o(done_o)
);

// File: tb/route_stepper_tb.sv
module route_stepper_tb_top;
  localparam int AW = 4;
  localparam int LW = $clog2(AW + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  int   checks = 0;
  int   errors = 0;
  bit   finished = 1'b0;

  // tree instance signals
  logic          t_ld_valid = 0, t_stp_valid = 0;
  logic [AW-1:0] t_src = '0, t_dst = '0;
  logic          t_ld_ready, t_stp_ready, t_hop, t_done;
  logic [1:0]    t_port;
  logic [LW-1:0] t_level;

  // butterfly instance signals
  logic          b_ld_valid = 0, b_stp_valid = 0;
  logic [AW-1:0] b_src = '0, b_dst = '0;
  logic          b_ld_ready, b_stp_ready, b_hop, b_done;
  logic [1:0]    b_port;
  logic [LW-1:0] b_level;

  always #10 clk = ~clk;

  route_stepper #(.AW(AW), .MODE(0)) dut_i (
    .clk(clk), .rst(rst),
    .ld_valid(t_ld_valid), .ld_ready(t_ld_ready),
    .ld_src(t_src), .ld_dst(t_dst),
    .stp_valid(t_stp_valid), .stp_ready(t_stp_ready),
    .port_o(t_port), .level_o(t_level),
    .hop_valid_o(t_hop), .done_o(t_done)
  );

  route_stepper #(.AW(AW), .MODE(1)) dut_b_i (
    .clk(clk), .rst(rst),
    .ld_valid(b_ld_valid), .ld_ready(b_ld_ready),
    .ld_src(b_src), .ld_dst(b_dst),
    .stp_valid(b_stp_valid), .stp_ready(b_stp_ready),
    .port_o(b_port), .level_o(b_level),
    .hop_valid_o(b_hop), .done_o(b_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int msb_of(input int v);
    int m = -1;
    for (int k = 0; k < AW; k++) if (v[k]) m = k;
    return m;
  endfunction

  task automatic tree_route(input int s, input int d);
    int r, m;
    r = s ^ d;
    t_src = AW'(s); t_dst = AW'(d); t_ld_valid = 1;
    @(negedge clk);
    t_ld_valid = 0;
    if (r == 0) begin
      chk("R3 done", t_done, 1);
      chk("R3 port local", t_port, 3);
      chk("R3 hop pulse", t_hop, 1);
      chk("R3 level", t_level, 0);
    end else begin
      chk("R2 not done after load", t_done, 0);
      chk("R2 stp_ready", t_stp_ready, 1);
      chk("R2 ld_ready low", t_ld_ready, 0);
      chk("R2 level zero", t_level, 0);
      m = msb_of(r);
      t_stp_valid = 1;
      for (int k = 0; k <= m; k++) begin
        @(negedge clk);
        chk("R4 port up", t_port, 2);
        chk("R4 level", t_level, k + 1);
        chk("R7 hop pulse", t_hop, 1);
      end
      for (int j = m; j >= 0; j--) begin
        @(negedge clk);
        chk("R5 child port", t_port, d[j]);
        chk("R5 level", t_level, j);
        chk("R5 done", t_done, (j == 0) ? 1 : 0);
      end
    end
    // step in done state is ignored
    t_stp_valid = 1;
    @(negedge clk);
    t_stp_valid = 0;
    chk("R8 no hop when done", t_hop, 0);
    chk("R8 done held", t_done, 1);
    chk("R8 port held", t_port, (r == 0) ? 3 : d[0]);
    chk("R8 level held", t_level, 0);
    chk("R2 ld_ready when done", t_ld_ready, 1);
  endtask

  task automatic fly_route(input int s, input int d);
    int r;
    r = s ^ d;
    b_src = AW'(s); b_dst = AW'(d); b_ld_valid = 1;
    @(negedge clk);
    b_ld_valid = 0;
    chk("R6 not done after load", b_done, 0);
    chk("R2 fly stp_ready", b_stp_ready, 1);
    chk("R2 fly level zero", b_level, 0);
    b_stp_valid = 1;
    for (int i = 0; i < AW; i++) begin
      @(negedge clk);
      chk("R6 straight/cross", b_port, r[i]);
      chk("R6 stage count", b_level, i + 1);
      chk("R6 done on last", b_done, (i == AW - 1) ? 1 : 0);
      chk("R7 fly hop pulse", b_hop, 1);
    end
    @(negedge clk);
    b_stp_valid = 0;
    chk("R8 fly no hop when done", b_hop, 0);
    chk("R8 fly port held", b_port, r[AW-1]);
    chk("R8 fly level held", b_level, AW);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 ld_ready", t_ld_ready, 1);
    chk("R1 stp_ready", t_stp_ready, 0);
    chk("R1 done", t_done, 0);
    chk("R1 hop", t_hop, 0);
    chk("R1 level", t_level, 0);
    chk("R1 port", t_port, 0);
    chk("R1 fly ld_ready", b_ld_ready, 1);
    chk("R1 fly done", b_done, 0);

    // R7: step while idle is ignored
    t_stp_valid = 1; b_stp_valid = 1;
    @(negedge clk);
    t_stp_valid = 0; b_stp_valid = 0;
    chk("R7 idle step ignored", t_hop, 0);
    chk("R7 idle level", t_level, 0);
    chk("R7 fly idle step ignored", b_hop, 0);

    // exhaustive sweeps
    for (int s = 0; s < (1 << AW); s++)
      for (int d = 0; d < (1 << AW); d++) begin
        tree_route(s, d);
        fly_route(s, d);
      end

    // R7 stall and R2 load during route: src 0 -> dst 15 climbs 4, descends 4
    t_src = 4'd0; t_dst = 4'd15; t_ld_valid = 1;
    @(negedge clk);
    t_ld_valid = 0; t_stp_valid = 1;
    @(negedge clk);
    t_stp_valid = 0;
    chk("R7 first hop level", t_level, 1);
    @(negedge clk);
    chk("R7 stall no hop", t_hop, 0);
    chk("R7 stall level held", t_level, 1);
    t_src = 4'd5; t_dst = 4'd5; t_ld_valid = 1;
    @(negedge clk);
    t_ld_valid = 0;
    chk("R2 load ignored done", t_done, 0);
    chk("R2 load ignored port", t_port, 2);
    chk("R2 load ignored level", t_level, 1);
    t_stp_valid = 1;
    for (int n = 0; n < 7; n++) @(negedge clk);
    t_stp_valid = 0;
    chk("R5 route completes after stall", t_done, 1);
    chk("R5 final child", t_port, 1);
    chk("R5 final level", t_level, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule